// File: doc/BRIEF.md
# Vector-looped carry-chained adder

This block runs a vector add-with-carry as a hardware loop over scalar 64-bit additions. It works on one element per clock, in strictly ascending element order. It owns a 32-entry register file of 64-bit words. For a vector length VL it takes element i from two source ranges that start at their base indices, adds the two words and the running carry, and writes the sum to the destination range at index base plus i.

The carry flag is read once, when the operation is accepted, and feeds element 0. Each later element takes the carry-out of the element before it. The whole vector therefore behaves as one wide integer add, and the final carry-out lands back in the carry flag. The block also sets a half-width carry flag from the carry out of bit 31 of the last element. It never touches the overflow and summary-overflow flags.

A host loads operands and reads results through a plain register port, and preloads the four flags through a flag write port. Control is a start strobe with busy and done outputs. There is no flow control at the edge: start is a one-cycle request that is either accepted or ignored.

Top module: `vec_carry_adder`

## Requirements
- R1: A start seen while busy is low is accepted. For an effective length L of 1 to 8, busy is high for exactly L cycles, beginning the cycle after acceptance, and done is high for the single cycle after the last busy cycle. A vl input above 8 is treated as 8.
- R2: A start seen while busy is high is ignored. The running operation's length, bases and results are unchanged.
- R3: In busy cycle k (k counts from 0), the block writes reg[base_dst+k] = reg[base_src1+k] + reg[base_src2+k] + carry-in, keeping the low 64 bits. Each element reads the file as left by all earlier elements.
- R4: Element 0 takes its carry-in from the carry flag as held before the accepting edge. Each later element takes the previous element's carry-out, so the destination words (lowest index least significant) equal the concatenated sources plus the initial carry.
- R5: On the edge that ends the last element, flags bit 0 (carry) takes that element's carry-out and flags bit 1 (half carry) takes the carry out of its bit 31. Neither flag changes during earlier busy cycles.
- R6: Flags bit 2 (overflow) and bit 3 (summary overflow) are never changed by an operation.
- R7: A start accepted with vl = 0 writes no register, leaves all flags unchanged, keeps busy low, and raises done on the next cycle.
- R8: Register indices base + k wrap modulo 32.
- R9: When busy is low, host_we writes host_wdata to host_addr and flag_we loads flag_wdata into flags, both at the next edge. Both writes are ignored while busy is high. host_rdata shows the addressed register combinationally.
- R10: Synchronous reset (rst high) clears all registers and flags, and clears busy and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one vector operation |
| vl | input | 4 | Vector length, 0 to 8; larger values act as 8 |
| base_dst | input | 5 | First destination register index |
| base_src1 | input | 5 | First index of source range one |
| base_src2 | input | 5 | First index of source range two |
| busy | output | 1 | High while elements are being processed |
| done | output | 1 | One-cycle pulse after an operation completes |
| host_we | input | 1 | Host register write enable |
| host_addr | input | 5 | Host register index for write and read |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Register contents at host_addr |
| flag_we | input | 1 | Flag preload enable |
| flag_wdata | input | 4 | Flag preload value, same layout as flags |
| flags | output | 4 | bit0 carry, bit1 half carry, bit2 overflow, bit3 summary overflow |

## Verification
After an accepted start, busy is due one edge later. The element k write shows through the host read port one edge after busy cycle k. The carry flags and done are due on the edge after the last busy cycle, or one edge after start when vl is 0. The bench steps a behavioural model on the same edges as the design and compares busy, done and flags at every falling edge, half a period away from where they change. Register contents are read back only after the operation finishes and the read path has settled. The wide-add check rebuilds the expected sum from the values the bench itself preloaded.

// File: rtl/vca_pkg.sv
package vca_pkg;

  // Flag word layout: bit 0 carry, bit 1 half carry, bit 2 overflow, bit 3 summary overflow
  typedef struct packed {
    logic so;
    logic ov;
    logic ca32;
    logic ca;
  } vca_flags_t;

  typedef enum logic [1:0] {
    LOOP_IDLE = 2'd0,
    LOOP_RUN  = 2'd1,
    LOOP_FIN  = 2'd2
  } loop_state_t;

endpackage

// File: rtl/vca_regfile.sv
module vca_regfile #(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int AW    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic [AW-1:0]   rh_addr,
  output logic [XLEN-1:0] rh_data
);

  logic [XLEN-1:0] mem [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= '0;
      end else if (we && (waddr == AW'(g))) begin
        mem[g] <= wdata;
      end
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rh_data = mem[rh_addr];

endmodule

// File: rtl/vca_elem_add.sv
module vca_elem_add #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            cin,
  output logic [XLEN-1:0] sum,
  output logic            cout,
  output logic            cout_half
);

  localparam int HALF = XLEN / 2;

  logic [XLEN:0] full_sum;
  logic [HALF:0] half_sum;

  always_comb begin
    full_sum = {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, cin};
    half_sum = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
  end

  assign sum       = full_sum[XLEN-1:0];
  assign cout      = full_sum[XLEN];
  assign cout_half = half_sum[HALF];

endmodule

// File: rtl/vca_seq.sv
module vca_seq
  import vca_pkg::*;
#(
  parameter int VLMAX = 8,
  parameter int VLW   = 4,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  output logic            accept,
  output logic            busy,
  output logic            done,
  output logic [IDXW-1:0] idx,
  output logic            last
);

  loop_state_t    state_q;
  logic [VLW-1:0] len_q;
  logic [VLW-1:0] len_sat;

  assign len_sat = (vl > VLW'(VLMAX)) ? VLW'(VLMAX) : vl;
  assign busy    = (state_q == LOOP_RUN);
  assign done    = (state_q == LOOP_FIN);
  assign accept  = start && !busy;
  assign last    = busy && ((VLW'(idx) + VLW'(1)) == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LOOP_IDLE;
      idx     <= '0;
      len_q   <= '0;
    end else if (busy) begin
      if (last) begin
        state_q <= LOOP_FIN;
      end else begin
        idx <= idx + IDXW'(1);
      end
    end else if (accept) begin
      idx   <= '0;
      len_q <= len_sat;
      state_q <= (len_sat == '0) ? LOOP_FIN : LOOP_RUN;
    end else begin
      state_q <= LOOP_IDLE;
    end
  end

endmodule

// File: rtl/vec_carry_adder.sv
module vec_carry_adder
  import vca_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int VLMAX = 8,
  localparam int AW   = $clog2(NREGS),
  localparam int VLW  = $clog2(VLMAX + 1),
  localparam int IDXW = (VLMAX > 1) ? $clog2(VLMAX) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [AW-1:0]   base_dst,
  input  logic [AW-1:0]   base_src1,
  input  logic [AW-1:0]   base_src2,
  output logic            busy,
  output logic            done,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [XLEN-1:0] host_wdata,
  output logic [XLEN-1:0] host_rdata,
  input  logic            flag_we,
  input  logic [3:0]      flag_wdata,
  output logic [3:0]      flags
);

  logic            accept;
  logic            last;
  logic [IDXW-1:0] idx;
  logic [AW-1:0]   bd_q, ba_q, bb_q;
  logic [AW-1:0]   addr_d, addr_a, addr_b;
  logic [XLEN-1:0] op_a, op_b, elem_sum;
  logic            chain_c, elem_cout, elem_cout_half;
  vca_flags_t      flags_q;
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  vca_seq #(.VLMAX(VLMAX), .VLW(VLW), .IDXW(IDXW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .accept(accept), .busy(busy), .done(done), .idx(idx), .last(last)
  );

  // Element k addresses: base + k, wrapping at the file size
  assign addr_d = bd_q + AW'(idx);
  assign addr_a = ba_q + AW'(idx);
  assign addr_b = bb_q + AW'(idx);

  // Loop owns the write port while busy; host writes are dropped then
  assign rf_we    = busy || host_we;
  assign rf_waddr = busy ? addr_d   : host_addr;
  assign rf_wdata = busy ? elem_sum : host_wdata;

  vca_regfile #(.XLEN(XLEN), .NREGS(NREGS), .AW(AW)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_addr(addr_a), .ra_data(op_a),
    .rb_addr(addr_b), .rb_data(op_b),
    .rh_addr(host_addr), .rh_data(host_rdata)
  );

  vca_elem_add #(.XLEN(XLEN)) u_add (
    .a(op_a), .b(op_b), .cin(chain_c),
    .sum(elem_sum), .cout(elem_cout), .cout_half(elem_cout_half)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bd_q    <= '0;
      ba_q    <= '0;
      bb_q    <= '0;
      chain_c <= 1'b0;
    end else if (accept) begin
      bd_q    <= base_dst;
      ba_q    <= base_src1;
      bb_q    <= base_src2;
      chain_c <= flags_q.ca;
    end else if (busy) begin
      chain_c <= elem_cout;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (last) begin
      flags_q.ca   <= elem_cout;
      flags_q.ca32 <= elem_cout_half;
    end else if (flag_we && !busy) begin
      flags_q <= vca_flags_t'(flag_wdata);
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
  parameter int VLMAX = 8,
  parameter int VLW   = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [VLW-1:0] vl,
  input logic           busy,
  input logic           done,
  input logic           flag_we,
  input logic [3:0]     flags
);

  logic [VLW-1:0] exp_len;
  logic [VLW:0]   run_cnt;
  logic [VLW-1:0] vl_eff;

  assign vl_eff = (vl > VLW'(VLMAX)) ? VLW'(VLMAX) : vl;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_len <= '0;
      run_cnt <= '0;
    end else if (start && !busy) begin
      exp_len <= vl_eff;
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vl != '0) |=> busy);

  p_busy_len_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_cnt == {1'b0, exp_len}));

  p_done_after_busy_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    (done && !(start && vl == '0)) |=> !done);

  p_done_not_busy_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_ignore_start_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && start && run_cnt + 1'b1 < {1'b0, exp_len}) |=> busy);

  p_ca_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(flags));

  p_so_ov_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(flags[3:2]));

  p_vl0_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vl == '0 && !flag_we) |=> (done && !busy && $stable(flags)));

endmodule

bind vec_carry_adder vca_checker #(.VLMAX(VLMAX), .VLW(VLW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .vl(vl), .busy(busy),
  .done(done), .flag_we(flag_we), .flags(flags)
);

// File: tb/test_vec_carry_adder.sv
`timescale 1ns/1ps
module test_vec_carry_adder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  vl = '0;
  logic [4:0]  base_dst = '0, base_src1 = '0, base_src2 = '0;
  logic        busy, done;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        flag_we = 1'b0;
  logic [3:0]  flag_wdata = '0;
  logic [3:0]  flags;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  vec_carry_adder i_vec_carry_adder (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .base_dst(base_dst), .base_src1(base_src1), .base_src2(base_src2),
    .busy(busy), .done(done),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .flags(flags)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_rf [32];
  logic [3:0]  m_flags;
  bit          m_busy, m_done, m_c;
  int          m_i, m_vl, m_bd, m_ba, m_bb;

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < 32; r++) m_rf[r] = '0;
      m_flags = '0; m_busy = 0; m_done = 0; m_c = 0; m_i = 0; m_vl = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        logic [64:0] s;
        logic [32:0] lo;
        logic [63:0] av, bv;
        av = m_rf[(m_ba + m_i) % 32];
        bv = m_rf[(m_bb + m_i) % 32];
        s  = {1'b0, av} + {1'b0, bv} + 65'(m_c);
        lo = {1'b0, av[31:0]} + {1'b0, bv[31:0]} + 33'(m_c);
        m_rf[(m_bd + m_i) % 32] = s[63:0];
        m_c = s[64];
        if (m_i == m_vl - 1) begin
          m_flags[0] = s[64];
          m_flags[1] = lo[32];
          m_busy = 0;
          m_done = 1;
        end else begin
          m_i++;
        end
      end else begin
        if (host_we) m_rf[host_addr] = host_wdata;
        if (start) begin
          m_vl = (vl > 8) ? 8 : int'(vl);
          m_bd = base_dst; m_ba = base_src1; m_bb = base_src2;
          m_c  = m_flags[0];
          m_i  = 0;
          if (m_vl == 0) m_done = 1; else m_busy = 1;
        end
        if (flag_we) m_flags = flag_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 busy", 64'(busy), 64'(m_busy));
      chk("R1 done", 64'(done), 64'(m_done));
      chk("R5 flags", 64'(flags), 64'(m_flags));
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic hwrite(input int a, input logic [63:0] d);
    host_we = 1; host_addr = 5'(a); host_wdata = d; tick(); host_we = 0;
  endtask

  task automatic fwrite(input logic [3:0] v);
    flag_we = 1; flag_wdata = v; tick(); flag_we = 0;
  endtask

  task automatic launch(input int d, input int a, input int b, input int n);
    base_dst = 5'(d); base_src1 = 5'(a); base_src2 = 5'(b); vl = 4'(n);
    start = 1; tick(); start = 0;
  endtask

  task automatic finish_op();
    while (m_busy) tick();
    tick();
  endtask

  task automatic readback(input string tag);
    for (int r = 0; r < 32; r++) begin
      host_addr = 5'(r); #1;
      chk(tag, host_rdata, m_rf[r]);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [255:0] wa, wb, wg;
    logic [256:0] wsum;
    repeat (3) tick();
    rst = 0;
    tick();
    cmp_on = 1;
    // R10: reset state
    chk("R10 busy", 64'(busy), 64'd0);
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 flags", 64'(flags), 64'd0);
    readback("R10 regs");

    // R3 R4 R5: VL=4 wide add, bases 0 / 4 / 8, carry in 1
    for (int k = 0; k < 4; k++) begin
      hwrite(4 + k, 64'hF0E1_D2C3_B4A5_9687 ^ (64'(k) * 64'h1357_9BDF_2468_ACE1));
      hwrite(8 + k, 64'h8F7E_6D5C_4B3A_2918 + (64'(k) << 40));
    end
    readback("R9 host write");
    fwrite(4'b0001);
    for (int k = 0; k < 4; k++) begin
      wa[64*k +: 64] = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(k) * 64'h1357_9BDF_2468_ACE1);
      wb[64*k +: 64] = 64'h8F7E_6D5C_4B3A_2918 + (64'(k) << 40);
    end
    wsum = {1'b0, wa} + {1'b0, wb} + 257'd1;
    launch(0, 4, 8, 4);
    chk("R1 busy after start", 64'(busy), 64'd1);
    finish_op();
    for (int k = 0; k < 4; k++) begin
      host_addr = 5'(k); #1;
      wg[64*k +: 64] = host_rdata;
    end
    for (int k = 0; k < 4; k++) chk("R4 wide word", wg[64*k +: 64], wsum[64*k +: 64]);
    chk("R4 final carry", 64'(flags[0]), 64'(wsum[256]));
    readback("R3 regs");

    // R4 R5: full ripple, all ones plus carry in
    for (int k = 0; k < 3; k++) begin
      hwrite(12 + k, '1);
      hwrite(16 + k, '0);
    end
    fwrite(4'b0001);
    launch(20, 12, 16, 3);
    finish_op();
    for (int k = 0; k < 3; k++) begin
      host_addr = 5'(20 + k); #1;
      chk("R4 ripple word", host_rdata, 64'd0);
    end
    chk("R5 ripple carry", 64'(flags[1:0]), 64'd3);

    // R5: VL=1 carry only out of bit 31
    hwrite(24, 64'h0000_0000_FFFF_FFFF);
    hwrite(25, 64'd0);
    fwrite(4'b0001);
    launch(26, 24, 25, 1);
    finish_op();
    chk("R5 half carry only", 64'(flags[1:0]), 64'b10);
    readback("R5 regs");

    // R6: overflow and summary overflow preserved
    fwrite(4'b1100);
    launch(2, 4, 8, 4);
    finish_op();
    chk("R6 so ov kept", 64'(flags[3:2]), 64'b11);
    fwrite(4'b0000);
    hwrite(4, '1); hwrite(8, '1);
    launch(2, 4, 8, 2);
    finish_op();
    chk("R6 so ov clear kept", 64'(flags[3:2]), 64'b00);

    // R7: VL=0
    fwrite(4'b0111);
    launch(0, 4, 8, 0);
    chk("R7 done next cycle", 64'(done), 64'd1);
    chk("R7 no busy", 64'(busy), 64'd0);
    tick();
    chk("R7 flags kept", 64'(flags), 64'h7);
    readback("R7 regs");

    // R8: wrap around the top of the file
    for (int k = 26; k < 32; k++) hwrite(k, 64'(k) * 64'h0101_0101_0101_0101);
    launch(30, 28, 26, 4);
    finish_op();
    readback("R8 wrap");

    // R2 and R9: second start and host writes while busy are dropped
    hwrite(21, 64'hDEAD_BEEF_0000_1111);
    launch(10, 0, 4, 5);
    base_dst = 5'd21; vl = 4'd1; start = 1; tick(); start = 0;
    chk("R2 still busy", 64'(busy), 64'd1);
    host_we = 1; host_addr = 5'd21; host_wdata = 64'h1234; tick(); host_we = 0;
    flag_we = 1; flag_wdata = 4'b1000; tick(); flag_we = 0;
    finish_op();
    host_addr = 5'd21; #1;
    chk("R9 busy write dropped", host_rdata, 64'hDEAD_BEEF_0000_1111);
    chk("R9 busy flag write dropped", 64'(flags[3]), 64'd0);
    readback("R2 regs");

    // R1: vl above the maximum acts as 8
    launch(16, 0, 8, 12);
    finish_op();
    readback("R1 saturated length");

    // R3: overlapping ranges, element reads earlier results
    launch(1, 0, 0, 6);
    finish_op();
    readback("R3 overlap");

    cmp_on = 0;
    report();
  end

endmodule